// File: doc/BRIEF.md
# Masked GPIO Port Controller

This block is a register-mapped controller for a group of 16-pin general-purpose I/O ports. Five ports is the default. Every pin has its own direction bit. Software can drive each port's output latch in three ways:

- a plain whole-port write;
- bit-wise set and clear writes, which touch only the bits written as 1;
- a masked-port write, which updates only the bits left open by that port's mask register.

Reads return the direction bits, the output latch, the mask, or the synchronized pin state. The pin state can be read in full or through the mask.

The bus side is a single-cycle slave with no wait states. A request is presented for one clock with a byte address, write strobe, byte enables and write data. Read data appears on the clock after the read request. On the pin side, each pin has an output value, an output enable and an input. Each port occupies 32 bytes of address space at `port * 0x20`. Within a port, the register is selected by address bits [4:2]:

| Code | Register | Function |
|------|----------|----------|
| 0 | direction | per-pin direction bits |
| 1 | output latch | whole-port write and read |
| 2 | set | writes 1s into the latch |
| 3 | clear | writes 0s into the latch |
| 4 | mask | per-port write and read mask |
| 5 | masked port | masked write and masked pin read |
| 6 | pin state | read only |
| 7 | unmapped | none |

Top module: `gpio_port_ctrl`

## Requirements
- R1: While and after reset, all direction bits, output latches and masks are 0. So `gpio_oe` and `gpio_out` are all 0 (every pin an input) and `bus_rdata` is 0.
- R2: A direction write (code 0) updates only the byte lanes whose enable is set. `bus_be[0]` covers pin bits 7:0 and `bus_be[1]` covers bits 15:8. `gpio_oe` shows the new bits (1 = output) from the clock edge that accepts the write.
- R3: An output-latch write (code 1) replaces the enabled byte lanes of the port's latch, so a full 16-bit port value is written in one access. `gpio_out` follows from the accepting edge.
- R4: A set write (code 2) drives high every enabled bit written as 1. Bits written as 0 keep their latch value.
- R5: A clear write (code 3) drives low every enabled bit written as 1. Bits written as 0 keep their latch value.
- R6: A masked-port write (code 5) updates only latch bits whose mask bit (code 4) is 0 and whose byte lane is enabled. Bits with a mask bit of 1 keep their previous value.
- R7: A masked-port read returns 0 in bits whose mask bit is 1, and the synchronized pin state in all other bits.
- R8: Pin inputs pass through two flops. A change on `gpio_in` before edge k is returned by a pin-state read (code 6) accepted at edge k+2, and not by one accepted at edge k+1.
- R9: A read accepted at edge k shows its value on `bus_rdata` after that edge. Codes 1, 2 and 3 read the output latch, code 0 reads direction and code 4 reads mask. Bits 31:16 are always 0, and `bus_rdata` is 0 after any edge with no read.
- R10: Port indices 5 to 7 (address bits [7:5]) and register code 7 are unmapped. Reads there return 0 and writes there change no state.
- R11: Byte enables `bus_be[3:2]` select no register bits. A write with only those lanes enabled changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| bus_req | input | 1 | Access request, valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: [7:5] port, [4:2] register code |
| bus_be | input | 4 | Byte enables for the write data lanes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| gpio_in | input | 80 | Pin inputs, port p at bits 16p+15:16p |
| gpio_out | output | 80 | Output latch values |
| gpio_oe | output | 80 | Output enables, equal to the direction bits |

## Verification
- Writes to the direction, latch and mask registers are due on `gpio_oe` and `gpio_out` after the single edge that accepts the request.
- Read data is due on `bus_rdata` after that same edge, and carries the register contents from before it.
- Pin changes need two edges to reach the pin-state and masked reads.

The bench keeps a behavioural model that advances once per clock with exactly these latencies. It compares all three outputs at the falling edge after every rising edge, so an early or late result shows up as a miscompare on that cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    REG_DIR   = 3'd0,
    REG_OUT   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_MASK  = 3'd4,
    REG_MPORT = 3'd5,
    REG_PIN   = 3'd6,
    REG_NONE  = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d;
  logic [W-1:0] sync_q;
  logic [W-1:0] sync_d;

  always_comb begin
    meta_d = din;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign dout = sync_q;

  // R8: the synchronized value is the input from two edges earlier
  a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ##1 (sync_q == $past(din, 2)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  gpio_reg_e reg_sel,
  input  logic [PW-1:0] lane_mask,
  input  logic [PW-1:0] wdata,
  input  logic [PW-1:0] pin_sync,
  output logic [PW-1:0] dir_q,
  output logic [PW-1:0] out_q,
  output logic [PW-1:0] mask_q,
  output logic [PW-1:0] rd_val
);
  logic [PW-1:0] dir_d;
  logic [PW-1:0] out_d;
  logic [PW-1:0] mask_d;
  logic [PW-1:0] wbits;
  logic [PW-1:0] open_bits;

  assign wbits     = wdata & lane_mask;
  assign open_bits = lane_mask & ~mask_q;

  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    mask_d = mask_q;
    if (wr_en) begin
      case (reg_sel)
        REG_DIR:   dir_d  = (dir_q & ~lane_mask) | wbits;
        REG_OUT:   out_d  = (out_q & ~lane_mask) | wbits;
        REG_SET:   out_d  = out_q | wbits;
        REG_CLR:   out_d  = out_q & ~wbits;
        REG_MASK:  mask_d = (mask_q & ~lane_mask) | wbits;
        REG_MPORT: out_d  = (out_q & ~open_bits) | (wdata & open_bits);
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
    end else begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_DIR:                   rd_val = dir_q;
      REG_OUT, REG_SET, REG_CLR: rd_val = out_q;
      REG_MASK:                  rd_val = mask_q;
      REG_MPORT:                 rd_val = pin_sync & ~mask_q;
      REG_PIN:                   rd_val = pin_sync;
      default:                   rd_val = '0;
    endcase
  end

  // R4: a set write only raises bits, and raises every written bit
  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_SET) |=>
      (out_q == ($past(out_q) | $past(wdata & lane_mask))));
  // R5: a clear write never raises a bit
  a_r5_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_CLR) |=> ((out_q & ~$past(out_q)) == '0));
  // R6: masked bits hold through a masked-port write
  a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_MPORT) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));
  // R10: without a write to this port no state moves
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W/8-1:0]         bus_be,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
  output logic [NUM_PORTS*PORT_W-1:0] gpio_out,
  output logic [NUM_PORTS*PORT_W-1:0] gpio_oe
);
  localparam int REG_LSB  = 2;
  localparam int PORT_LSB = REG_LSB + 3;
  localparam int PIDX_W   = ADDR_W - PORT_LSB;
  localparam int ALL_W    = NUM_PORTS * PORT_W;

  logic [PIDX_W-1:0] port_idx;
  gpio_reg_e         reg_sel;
  logic              port_hit;
  logic              reg_hit;
  logic              wr_acc;
  logic              rd_acc;
  logic [PORT_W-1:0] lane_mask;
  logic [ALL_W-1:0]  pin_sync;
  logic [PORT_W-1:0] rd_vals [NUM_PORTS];
  logic [PORT_W-1:0] rd_pick;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  assign port_idx = bus_addr[ADDR_W-1:PORT_LSB];
  assign reg_sel  = gpio_reg_e'(bus_addr[PORT_LSB-1:REG_LSB]);
  assign port_hit = ({1'b0, port_idx} < (PIDX_W+1)'(NUM_PORTS));
  assign reg_hit  = (reg_sel != REG_NONE);
  assign wr_acc   = bus_req && bus_we && port_hit && reg_hit;
  assign rd_acc   = bus_req && !bus_we && port_hit && reg_hit;

  for (genvar b = 0; b < PORT_W; b++) begin : g_lane
    assign lane_mask[b] = bus_be[b/8];
  end

  gpio_sync #(.W(ALL_W)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (gpio_in),
    .dout  (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] dir_w;
    logic [PORT_W-1:0] out_w;
    logic [PORT_W-1:0] mask_w;
    logic              sel_w;

    assign sel_w = wr_acc && (port_idx == PIDX_W'(p));

    gpio_port #(.PW(PORT_W)) port_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (sel_w),
      .reg_sel   (reg_sel),
      .lane_mask (lane_mask),
      .wdata     (bus_wdata[PORT_W-1:0]),
      .pin_sync  (pin_sync[p*PORT_W +: PORT_W]),
      .dir_q     (dir_w),
      .out_q     (out_w),
      .mask_q    (mask_w),
      .rd_val    (rd_vals[p])
    );

    assign gpio_oe[p*PORT_W +: PORT_W]  = dir_w;
    assign gpio_out[p*PORT_W +: PORT_W] = out_w;
  end

  always_comb begin
    rd_pick = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_idx == PIDX_W'(p)) rd_pick = rd_vals[p];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_acc) rdata_d[PORT_W-1:0] = rd_pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R9: no read accepted, so read data returns to 0
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> (bus_rdata == '0));
  // R9: upper half of read data is always 0
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PORT_W] == '0);
  // R10: reads of unmapped ports return 0
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && !port_hit) |=> (bus_rdata == '0));
  // R11: writes with only upper lanes enabled leave outputs unchanged
  a_r11_upper_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_be[1:0] == 2'b00) |=> ($stable(gpio_out) && $stable(gpio_oe)));
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;
  localparam int NP = 5;
  localparam int PW = 16;
  localparam int AW = 8;
  localparam int DW = 32;

  logic            clk;
  logic            rst_n;
  logic            bus_req;
  logic            bus_we;
  logic [AW-1:0]   bus_addr;
  logic [3:0]      bus_be;
  logic [DW-1:0]   bus_wdata;
  logic [DW-1:0]   bus_rdata;
  logic [NP*PW-1:0] gpio_in;
  logic [NP*PW-1:0] gpio_out;
  logic [NP*PW-1:0] gpio_oe;

  int    n_vec;
  int    n_bad;
  string cur_req;

  logic [PW-1:0] dir_m  [NP];
  logic [PW-1:0] out_m  [NP];
  logic [PW-1:0] mask_m [NP];
  logic [NP*PW-1:0] s1_m;
  logic [NP*PW-1:0] s2_m;
  logic [DW-1:0]    rdata_m;

  gpio_port_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_in   (gpio_in),
    .gpio_out  (gpio_out),
    .gpio_oe   (gpio_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
    int p = int'(a[7:5]);
    int r = int'(a[4:2]);
    logic [PW-1:0] pins;
    if (p >= NP || r == 7) return '0;
    pins = s2_m[p*PW +: PW];
    case (r)
      0:       return {16'h0, dir_m[p]};
      1, 2, 3: return {16'h0, out_m[p]};
      4:       return {16'h0, mask_m[p]};
      5:       return {16'h0, pins & ~mask_m[p]};
      default: return {16'h0, pins};
    endcase
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [3:0] be, logic [DW-1:0] d);
    int p = int'(a[7:5]);
    int r = int'(a[4:2]);
    logic [PW-1:0] lm;
    logic [PW-1:0] wv;
    lm = {{8{be[1]}}, {8{be[0]}}};
    wv = d[PW-1:0];
    if (p >= NP || r == 7) return;
    for (int b = 0; b < PW; b++) begin
      if (lm[b]) begin
        case (r)
          0: dir_m[p][b]  = wv[b];
          1: out_m[p][b]  = wv[b];
          2: if (wv[b]) out_m[p][b] = 1'b1;
          3: if (wv[b]) out_m[p][b] = 1'b0;
          4: mask_m[p][b] = wv[b];
          5: if (!mask_m[p][b]) out_m[p][b] = wv[b];
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare();
    logic [NP*PW-1:0] exp_out;
    logic [NP*PW-1:0] exp_oe;
    for (int p = 0; p < NP; p++) begin
      exp_out[p*PW +: PW] = out_m[p];
      exp_oe[p*PW +: PW]  = dir_m[p];
    end
    n_vec++;
    if (gpio_out !== exp_out || gpio_oe !== exp_oe || bus_rdata !== rdata_m) begin
      n_bad++;
      $display("FAIL %s: out=%h oe=%h rdata=%h expected out=%h oe=%h rdata=%h",
               cur_req, gpio_out, gpio_oe, bus_rdata, exp_out, exp_oe, rdata_m);
    end
  endtask

  task automatic tick();
    logic [DW-1:0] rd_n;
    rd_n = '0;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        dir_m[p] = '0; out_m[p] = '0; mask_m[p] = '0;
      end
      s1_m = '0; s2_m = '0;
    end else begin
      if (bus_req && !bus_we) rd_n = model_read(bus_addr);
      if (bus_req && bus_we) model_write(bus_addr, bus_be, bus_wdata);
      s2_m = s1_m;
      s1_m = gpio_in;
    end
    rdata_m = rd_n;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    bus_req = 1'b0; bus_we = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int port, int code, logic [3:0] be, logic [DW-1:0] d);
    bus_req = 1'b1; bus_we = 1'b1;
    bus_addr = AW'((port << 5) | (code << 2));
    bus_be = be; bus_wdata = d;
    tick();
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int port, int code);
    bus_req = 1'b1; bus_we = 1'b0;
    bus_addr = AW'((port << 5) | (code << 2));
    bus_be = 4'h0; bus_wdata = '0;
    tick();
    bus_req = 1'b0;
  endtask

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0; gpio_in = '0;
    cur_req = "R1";
    for (int p = 0; p < NP; p++) begin
      dir_m[p] = '0; out_m[p] = '0; mask_m[p] = '0;
    end
    s1_m = '0; s2_m = '0; rdata_m = '0;
    @(negedge clk);
    gpio_in = {NP{16'hFFFF}};
    tick(); tick();
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    for (int p = 0; p < NP; p++) rd(p, 1);

    cur_req = "R2";
    wr(0, 0, 4'b0001, 32'hFFFF_FFFF);
    wr(0, 0, 4'b0010, 32'h0000_A500);
    rd(0, 0);

    cur_req = "R3";
    wr(1, 1, 4'hF, 32'h1234_ABCD);
    wr(4, 1, 4'b0011, 32'h0000_C3C3);
    cur_req = "R9";
    rd(1, 1); rd(1, 2); rd(1, 3); idle(1);

    cur_req = "R4";
    wr(1, 2, 4'b0011, 32'h0000_0F00);
    wr(1, 2, 4'b0001, 32'h0000_FF33);
    rd(1, 2);

    cur_req = "R5";
    wr(1, 3, 4'b0001, 32'h0000_00FF);
    wr(1, 3, 4'b0011, 32'h0000_8001);
    rd(1, 1);

    cur_req = "R6";
    wr(2, 4, 4'b0011, 32'h0000_00FF);
    wr(2, 1, 4'b0011, 32'h0000_AAAA);
    wr(2, 5, 4'b0011, 32'h0000_5555);
    wr(2, 4, 4'b0010, 32'h0000_F000);
    wr(2, 5, 4'b0010, 32'h0000_0000);
    rd(2, 4); rd(2, 1);

    cur_req = "R8";
    @(negedge clk);
    gpio_in[2*PW +: PW] = 16'h1234;
    rd(2, 6);
    rd(2, 6);
    rd(2, 6);
    gpio_in[3*PW +: PW] = 16'h0F0F;
    idle(3);
    rd(3, 6);

    cur_req = "R7";
    rd(2, 5);
    wr(2, 4, 4'b0011, 32'h0000_0FF0);
    rd(2, 5);
    wr(2, 4, 4'b0011, 32'h0000_0000);
    rd(2, 5);

    cur_req = "R10";
    wr(5, 1, 4'hF, 32'hFFFF_FFFF);
    wr(7, 0, 4'hF, 32'hFFFF_FFFF);
    wr(0, 7, 4'hF, 32'hFFFF_FFFF);
    rd(5, 1); rd(6, 6); rd(0, 7); rd(0, 0);

    cur_req = "R11";
    wr(3, 1, 4'b1100, 32'hFFFF_FFFF);
    wr(3, 0, 4'b1100, 32'hFFFF_FFFF);
    rd(3, 1); rd(3, 0);

    cur_req = "R3";
    for (int p = 0; p < NP; p++) begin
      wr(p, 0, 4'hF, 32'(16'h0101 << p));
      wr(p, 1, 4'hF, 32'(16'hBEEF ^ (p * 16'h1111)));
      rd(p, 1);
    end
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule